// File: doc/BRIEF.md
# Dual-Flash Plus SRAM Shared-Bus Access Controller

This block sits on the host side of a memory package that holds two flash banks and one SRAM bank behind a single shared bus. Address, write data, read data and the read and write strobes are common to all three banks. The controller takes one request at a time, each carrying an operation code, an address and write data. It decodes the upper address bits into a target bank and runs a fixed-length bus access. During that access it drives the one active-low flash select, or the active-low and active-high pair that together select the SRAM.

A program or erase issued to a flash bank makes that bank busy for a long time. The controller keeps one busy flag per flash bank. A flag clears either after a fixed countdown or on an external completion pulse for that bank. Only combinations that are safe to run concurrently are let through. One flash bank may be read while the other one is busy. The SRAM may be read or written at any time. No second program or erase may start while a bank is busy, and a busy bank may not be read. A request that breaks these rules is held at the head with ready low until the conflict clears. Requests behind it wait their turn.

Top module: `combo_bank_ctrl`

## Requirements
- R1: The target bank comes from the two top address bits. 00 selects flash bank 1, 01 selects flash bank 2, and 1x selects the SRAM. A flash access drives `fl_sel_n` low. An SRAM access drives `sr_sel_n` low and `sr_sel_p` high.
- R2: The flash and the SRAM are never selected in the same cycle. When no access runs, the bus is in standby: `fl_sel_n`=1, `sr_sel_n`=1, `sr_sel_p`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dout_en`=0.
- R3: A read (op 0) holds the bank select and `mem_oe_n` low for exactly RD_WAIT cycles. In the next cycle `rd_valid` is high for one cycle, and `rd_data` holds the `mem_din` value sampled in the last strobe cycle.
- R4: A write (any op other than 0) holds the bank select and `mem_we_n` low for exactly RD_WAIT cycles, with `mem_dout` equal to the request's write data. `mem_dout_en` is high only while `mem_we_n` is low, and never while `mem_oe_n` is low.
- R5: Op codes are 0 read, 1 write, 2 program and 3 erase. Ops 1, 2 and 3 to a flash bank set that bank's bit in `flash_busy` from the cycle after the request is accepted (bit 0 for bank 1, bit 1 for bank 2). To the SRAM, every nonzero op is a plain write.
- R6: A busy flag clears after BUSY_CYC cycles, or in the cycle after a pulse on that bank's `flash_done` bit, whichever comes first.
- R7: While one flash bank is busy, a read of the other flash bank is accepted and completes normally.
- R8: A read of a busy flash bank keeps `req_ready` low until that bank's busy flag clears.
- R9: A write, program or erase to any flash bank keeps `req_ready` low while either flash bank is busy, so at most one bank is busy at a time.
- R10: SRAM reads and writes are accepted while a flash bank is busy.
- R11: Requests are served one at a time. `req_ready` is low for the whole time a bus access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 program, 3 erase |
| req_addr | input | AW | Request address; top two bits pick the bank |
| req_wdata | input | DW | Write data for the request |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| rd_valid | output | 1 | One-cycle pulse marking read data |
| rd_data | output | DW | Captured read data |
| flash_done | input | 2 | Per-bank completion pulse that ends busy early |
| flash_busy | output | 2 | Per-bank busy flags |
| mem_addr | output | AW | Shared bus address |
| mem_dout | output | DW | Shared bus write data |
| mem_dout_en | output | 1 | Drive enable for write data |
| mem_din | input | DW | Shared bus read data |
| fl_sel_n | output | 1 | Active-low flash select |
| sr_sel_n | output | 1 | Active-low SRAM select |
| sr_sel_p | output | 1 | Active-high SRAM select |
| mem_oe_n | output | 1 | Active-low output-enable strobe |
| mem_we_n | output | 1 | Active-low write strobe |

## Verification
The hardest case to reach from the ports is a request stuck behind a busy bank, released by a `flash_done` pulse instead of by the countdown. A second case needs SRAM traffic to interleave with a long erase while the countdown still runs. The bench starts a program on bank 1 and reads bank 2 during it. It then presents a bank-1 read, checks that ready stays low, and pulses the completion input. Next it starts an erase on bank 2, offers a blocked program, then withdraws it. It runs SRAM writes and reads while the erase continues, and finally measures how many cycles the busy flag stayed high.

// File: rtl/cbc_pkg.sv
// Shared types for the shared-bus bank controller.
// Assumes a two-bit operation code and three target banks.
package cbc_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_PROG  = 2'd2,
        OP_ERASE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        TGT_FL1  = 2'd0,
        TGT_FL2  = 2'd1,
        TGT_SRAM = 2'd2
    } tgt_e;
endpackage

// File: rtl/cbc_decode.sv
// Address decode and concurrency check for the request at the head.
// Assumes the two top address bits pick the bank and busy is per flash bank.
module cbc_decode
    import cbc_pkg::*;
(
    input  logic [1:0] bank_bits,
    input  logic [1:0] op,
    input  logic [1:0] busy,
    output tgt_e       tgt,
    output logic       is_wr,
    output logic       stall
);
    logic is_flash;
    logic own_busy;

    // Map the top address bits onto a bank.
    always_comb begin
        if (bank_bits[1])      tgt = TGT_SRAM;
        else if (bank_bits[0]) tgt = TGT_FL2;
        else                   tgt = TGT_FL1;
    end

    // Classify the operation and look up the target's busy flag.
    always_comb begin
        is_wr    = (op_e'(op) != OP_READ);
        is_flash = (tgt != TGT_SRAM);
        own_busy = (tgt == TGT_FL1) ? busy[0] : busy[1];
    end

    // Hold flash reads of a busy bank and any flash write while a bank is busy.
    always_comb begin
        stall = is_flash && (own_busy || (is_wr && (|busy)));
    end
endmodule

// File: rtl/cbc_busy.sv
// Busy tracker for one flash bank.
// Sets on start, clears after CNT_MAX cycles or the cycle after a done pulse.
// Assumes start never arrives while busy (the decoder stalls it).
module cbc_busy #(
    parameter int CNT_MAX = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    output logic busy
);
    localparam int CW = $clog2(CNT_MAX + 1);

    logic [CW-1:0] cnt;

    // Load on start, count down while busy, clear on expiry or done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CW'(CNT_MAX);
        end else if (busy) begin
            if (done || cnt == CW'(1)) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    // R5
    property start_sets_busy_p;
        @(posedge clk) disable iff (!rst_n) start |=> busy;
    endproperty
    start_sets_busy_chk: assert property (start_sets_busy_p);

    // R6
    property done_clears_p;
        @(posedge clk) disable iff (!rst_n) (done && busy && !start) |=> !busy;
    endproperty
    done_clears_chk: assert property (done_clears_p);

    // R6
    property cnt_window_p;
        @(posedge clk) disable iff (!rst_n) (cnt <= CW'(CNT_MAX)) && (busy || cnt == '0);
    endproperty
    cnt_window_chk: assert property (cnt_window_p);
endmodule

// File: rtl/cbc_seq.sv
// Bus access sequencer: runs one read or write of WAIT strobe cycles.
// Drives the bank selects and strobes from registered state, then
// returns read data one cycle after the strobes end.
// Assumes start is only raised while idle and WAIT >= 1.
module cbc_seq
    import cbc_pkg::*;
#(
    parameter int AW   = 12,
    parameter int DW   = 16,
    parameter int WAIT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  tgt_e          tgt,
    input  logic          is_wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] mem_din,
    output logic          idle,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dout,
    output logic          mem_dout_en,
    output logic          fl_sel_n,
    output logic          sr_sel_n,
    output logic          sr_sel_p,
    output logic          mem_oe_n,
    output logic          mem_we_n
);
    localparam int CW = $clog2(WAIT + 1);

    typedef enum logic {S_IDLE, S_ACC} st_e;

    st_e           st;
    logic [CW-1:0] cnt;
    tgt_e          tgt_q;
    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          acc;

    // Access state, strobe counter, request latch and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            cnt      <= '0;
            tgt_q    <= TGT_FL1;
            wr_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start) begin
                        st      <= S_ACC;
                        cnt     <= '0;
                        tgt_q   <= tgt;
                        wr_q    <= is_wr;
                        addr_q  <= addr;
                        wdata_q <= wdata;
                    end
                end
                default: begin
                    if (cnt == CW'(WAIT - 1)) begin
                        st <= S_IDLE;
                        if (!wr_q) begin
                            rd_valid <= 1'b1;
                            rd_data  <= mem_din;
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
            endcase
        end
    end

    // Derive bus selects and strobes from the access state.
    always_comb begin
        acc         = (st == S_ACC);
        idle        = !acc;
        fl_sel_n    = !(acc && tgt_q != TGT_SRAM);
        sr_sel_n    = !(acc && tgt_q == TGT_SRAM);
        sr_sel_p    = acc && tgt_q == TGT_SRAM;
        mem_oe_n    = !(acc && !wr_q);
        mem_we_n    = !(acc && wr_q);
        mem_dout_en = acc && wr_q;
        mem_addr    = addr_q;
        mem_dout    = wdata_q;
    end

    // R2
    property one_bank_p;
        @(posedge clk) disable iff (!rst_n)
            $countones({!fl_sel_n, (!sr_sel_n && sr_sel_p)}) <= 1;
    endproperty
    one_bank_chk: assert property (one_bank_p);

    // R2
    property standby_p;
        @(posedge clk) disable iff (!rst_n)
            idle |-> (fl_sel_n && sr_sel_n && !sr_sel_p && mem_oe_n && mem_we_n && !mem_dout_en);
    endproperty
    standby_chk: assert property (standby_p);

    // R3
    property rd_after_oe_p;
        @(posedge clk) disable iff (!rst_n) rd_valid |-> $past(!mem_oe_n) && mem_oe_n;
    endproperty
    rd_after_oe_chk: assert property (rd_after_oe_p);

    // R4
    property no_drive_on_read_p;
        @(posedge clk) disable iff (!rst_n) mem_dout_en |-> (mem_oe_n && !mem_we_n);
    endproperty
    no_drive_on_read_chk: assert property (no_drive_on_read_p);

    // R11
    property start_only_idle_p;
        @(posedge clk) disable iff (!rst_n) start |-> (st == S_IDLE);
    endproperty
    start_only_idle_chk: assert property (start_only_idle_p);
endmodule

// File: rtl/combo_bank_ctrl.sv
// Top of the shared-bus bank controller for two flash banks plus one SRAM.
// Accepts one request at a time, enforces which bank operations may run
// concurrently, tracks per-bank busy time and runs the bus access.
// Assumes the requester holds its request stable until req_ready.
module combo_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int AW       = 12,
    parameter int DW       = 16,
    parameter int RD_WAIT  = 3,
    parameter int BUSY_CYC = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    input  logic [1:0]    flash_done,
    output logic [1:0]    flash_busy,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dout,
    output logic          mem_dout_en,
    input  logic [DW-1:0] mem_din,
    output logic          fl_sel_n,
    output logic          sr_sel_n,
    output logic          sr_sel_p,
    output logic          mem_oe_n,
    output logic          mem_we_n
);
    localparam int NFL = 2;

    tgt_e           tgt;
    logic           is_wr;
    logic           stall;
    logic           seq_idle;
    logic           accept;
    logic [NFL-1:0] busy_start;

    cbc_decode u_decode (
        .bank_bits (req_addr[AW-1:AW-2]),
        .op        (req_op),
        .busy      (flash_busy),
        .tgt       (tgt),
        .is_wr     (is_wr),
        .stall     (stall)
    );

    // Accept the head request when the bus is free and no conflict exists.
    always_comb begin
        req_ready = seq_idle && !stall;
        accept    = req_valid && req_ready;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NFL; gi++) begin : g_bank
            // Start the bank's busy period on an accepted flash write.
            always_comb begin
                busy_start[gi] = accept && is_wr && (tgt == tgt_e'(gi));
            end

            cbc_busy #(.CNT_MAX(BUSY_CYC)) u_busy (
                .clk   (clk),
                .rst_n (rst_n),
                .start (busy_start[gi]),
                .done  (flash_done[gi]),
                .busy  (flash_busy[gi])
            );
        end
    endgenerate

    cbc_seq #(.AW(AW), .DW(DW), .WAIT(RD_WAIT)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .tgt         (tgt),
        .is_wr       (is_wr),
        .addr        (req_addr),
        .wdata       (req_wdata),
        .mem_din     (mem_din),
        .idle        (seq_idle),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .mem_addr    (mem_addr),
        .mem_dout    (mem_dout),
        .mem_dout_en (mem_dout_en),
        .fl_sel_n    (fl_sel_n),
        .sr_sel_n    (sr_sel_n),
        .sr_sel_p    (sr_sel_p),
        .mem_oe_n    (mem_oe_n),
        .mem_we_n    (mem_we_n)
    );

    // R9
    property single_busy_p;
        @(posedge clk) disable iff (!rst_n) !(flash_busy[0] && flash_busy[1]);
    endproperty
    single_busy_chk: assert property (single_busy_p);

    // R8
    property no_read_busy1_p;
        @(posedge clk) disable iff (!rst_n)
            (accept && !req_addr[AW-1] && !req_addr[AW-2]) |-> !flash_busy[0];
    endproperty
    no_read_busy1_chk: assert property (no_read_busy1_p);

    // R8
    property no_read_busy2_p;
        @(posedge clk) disable iff (!rst_n)
            (accept && !req_addr[AW-1] && req_addr[AW-2]) |-> !flash_busy[1];
    endproperty
    no_read_busy2_chk: assert property (no_read_busy2_p);

    // R11
    property no_accept_busy_bus_p;
        @(posedge clk) disable iff (!rst_n) (!mem_oe_n || !mem_we_n) |-> !req_ready;
    endproperty
    no_accept_busy_bus_chk: assert property (no_accept_busy_bus_p);
endmodule

// File: tb/combo_bank_ctrl_bench.sv
module combo_bank_ctrl_bench;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int RD_WAIT = 3;
    localparam int BUSY_CYC = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rd_valid;
    logic [DW-1:0] rd_data;
    logic [1:0] flash_done = '0;
    logic [1:0] flash_busy;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dout, mem_din;
    logic mem_dout_en, fl_sel_n, sr_sel_n, sr_sel_p, mem_oe_n, mem_we_n;

    always #4 clk = ~clk;

    combo_bank_ctrl #(.AW(AW), .DW(DW), .RD_WAIT(RD_WAIT), .BUSY_CYC(BUSY_CYC)) u_combo_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .flash_done(flash_done),
        .flash_busy(flash_busy), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .mem_din(mem_din), .fl_sel_n(fl_sel_n),
        .sr_sel_n(sr_sel_n), .sr_sel_p(sr_sel_p), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {4'hA, a} ^ 16'h0F0F;
    endfunction

    logic sr_on;
    assign sr_on = !sr_sel_n && sr_sel_p;
    assign mem_din = (!mem_oe_n && (!fl_sel_n || sr_on)) ? pat(mem_addr) : '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // monitor state
    bit saw_fl, saw_sr;
    int oe_cnt, we_cnt, clash, rdy_in_acc, drive_on_read, busy1_hi;
    logic [DW-1:0] seen_dout;

    always @(negedge clk) begin
        if (!fl_sel_n) saw_fl = 1;
        if (sr_on) saw_sr = 1;
        if (!fl_sel_n && sr_on) clash++;
        if (!mem_oe_n) oe_cnt++;
        if (!mem_we_n) we_cnt++;
        if ((!mem_oe_n || !mem_we_n) && req_ready) rdy_in_acc++;
        if (mem_dout_en && !mem_oe_n) drive_on_read++;
        if (mem_dout_en) seen_dout = mem_dout;
        if (flash_busy[1]) busy1_hi++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        saw_fl = 0; saw_sr = 0; oe_cnt = 0; we_cnt = 0;
    endtask

    logic [DW-1:0] last_rd;

    task automatic access(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        @(negedge clk);
        clr_mon();
        req_valid = 1; req_op = op; req_addr = a; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 0;
        if (op == 2'd0) begin
            @(negedge clk);
            while (!rd_valid) @(negedge clk);
            last_rd = rd_data;
        end else begin
            repeat (RD_WAIT + 1) @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          is_sram;
    } vec_t;

    localparam vec_t VEC [0:4] = '{
        '{op: 2'd0, addr: 12'h005, wdata: 16'h0000, is_sram: 1'b0},
        '{op: 2'd0, addr: 12'h432, wdata: 16'h0000, is_sram: 1'b0},
        '{op: 2'd1, addr: 12'h8A0, wdata: 16'h1234, is_sram: 1'b1},
        '{op: 2'd0, addr: 12'hC0F, wdata: 16'h0000, is_sram: 1'b1},
        '{op: 2'd3, addr: 12'h9FF, wdata: 16'hBEEF, is_sram: 1'b1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2 reset standby
        chk("R2 reset standby", {fl_sel_n, sr_sel_n, sr_sel_p, mem_oe_n, mem_we_n, mem_dout_en},
            {1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0});
        chk("R5 reset busy", flash_busy, 2'b00);
        chk("R3 reset rd_valid", rd_valid, 1'b0);
        chk("R11 reset ready", req_ready, 1'b1);

        // vector table: R1 R3 R4
        for (int i = 0; i < 5; i++) begin
            access(VEC[i].op, VEC[i].addr, VEC[i].wdata);
            chk($sformatf("R1 vec%0d flash sel", i), saw_fl, !VEC[i].is_sram);
            chk($sformatf("R1 vec%0d sram sel", i), saw_sr, VEC[i].is_sram);
            if (VEC[i].op == 2'd0) begin
                chk($sformatf("R3 vec%0d oe cycles", i), oe_cnt, RD_WAIT);
                chk($sformatf("R3 vec%0d rd_data", i), last_rd, pat(VEC[i].addr));
            end else begin
                chk($sformatf("R4 vec%0d we cycles", i), we_cnt, RD_WAIT);
                chk($sformatf("R4 vec%0d dout", i), seen_dout, VEC[i].wdata);
            end
        end
        chk("R5 sram write no busy", flash_busy, 2'b00);

        // R5 program bank 1
        access(2'd2, 12'h010, 16'h7777);
        chk("R5 program sets busy0", flash_busy, 2'b01);
        // R7 read other flash bank while busy
        access(2'd0, 12'h455, '0);
        chk("R7 read bank2 while bank1 busy", last_rd, pat(12'h455));
        // R8 read busy bank stalls
        @(negedge clk);
        req_valid = 1; req_op = 2'd0; req_addr = 12'h066;
        begin
            bit rdy_seen = 0;
            repeat (3) begin @(negedge clk); if (req_ready) rdy_seen = 1; end
            chk("R8 read busy bank stalls", rdy_seen, 1'b0);
        end
        flash_done = 2'b01;
        @(negedge clk);
        flash_done = 2'b00;
        chk("R6 done pulse clears busy0", flash_busy, 2'b00);
        chk("R8 ready after clear", req_ready, 1'b1);
        clr_mon();
        @(posedge clk); #1;
        req_valid = 0;
        @(negedge clk);
        while (!rd_valid) @(negedge clk);
        chk("R8 released read data", rd_data, pat(12'h066));

        // R9 erase bank2 then program bank1 stalls
        busy1_hi = 0;
        access(2'd3, 12'h400, 16'h0000);
        chk("R5 erase sets busy1", flash_busy, 2'b10);
        @(negedge clk);
        req_valid = 1; req_op = 2'd2; req_addr = 12'h020;
        begin
            bit rdy_seen = 0;
            repeat (3) begin @(negedge clk); if (req_ready) rdy_seen = 1; end
            chk("R9 program while other busy stalls", rdy_seen, 1'b0);
        end
        req_valid = 0;
        // R10 SRAM during busy
        access(2'd1, 12'h8F0, 16'h55AA);
        chk("R10 sram write during busy", {saw_sr, seen_dout}, {1'b1, 16'h55AA});
        access(2'd0, 12'h8F0, '0);
        chk("R10 sram read during busy", last_rd, pat(12'h8F0));
        chk("R10 busy still held", flash_busy, 2'b10);
        begin
            int w = 0;
            while (flash_busy[1] && w < 500) begin @(negedge clk); w++; end
        end
        chk("R6 countdown length", busy1_hi, BUSY_CYC);
        access(2'd2, 12'h020, 16'h1111);
        chk("R9 program accepted after clear", flash_busy, 2'b01);

        chk("R2 never both selected", clash, 0);
        chk("R11 no ready during access", rdy_in_acc, 0);
        chk("R4 no drive during read", drive_on_read, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule